// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block sits on the controller side of an asynchronous EDO DRAM. It brings the memory out of power-up and keeps it refreshed. It runs from one system clock, and every delay is a cycle count set by a parameter. After reset it holds all strobes inactive through a timed pause. It then runs a burst of wake-up CAS-before-RAS (CBR) refresh cycles and only after that reports the memory as usable. From then on it issues one CBR refresh per refresh slot. The slot is the full refresh period divided by the number of rows, and a free-running down-counter times it. The CBR cycles use the DRAM's internal row counter, so no row address is ever driven.

An access engine asks for the bus with a level request and receives a grant. The grant is given only when the sequencer is idle and is held for as long as the request stays high. The access engine drives the DRAM pins itself while it holds the grant, and the sequencer's strobes stay inactive during that time. A refresh that falls due is served at the next idle point, ahead of any pending request. A request held so long that no refresh starts for a whole refresh period is treated as a lapse. In that case the wake-up burst is repeated before anything else.

A self-refresh request makes the block refresh every row in one burst. It then starts a CBR cycle and keeps RAS low for at least the minimum self-refresh time, and for as long as the request stays high. On release it holds RAS high for the longer self-refresh precharge, then refreshes every row again before returning to idle. Both CAS strobes always move together, and WE is never asserted.

Top module: `dram_refresh_seq`

## Requirements
- R1: From reset release, RAS, CASL and CASH stay high for PAUSE_CYC+1 cycles. During the pause `ready` is 0 and `busy` is 1. Reset itself shows the same values.
- R2: After the pause, WAKE_CNT CBR cycles run back to back. Each cycle has CAS low for T_CSR cycles with RAS high, then both low for T_RAS cycles, then both high for T_RP cycles. `ready` rises one cycle after the last precharge cycle.
- R3: `we_n` is 1 at all times.
- R4: A refresh slot falls due every REF_PERIOD/ROWS cycles, counted from reset release. Each due slot is served by one CBR cycle, which starts one cycle after the idle point that picks it up.
- R5: At an idle point the priority order is: lapse recovery, then a due refresh, then a self-refresh request, then an access request.
- R6: `acc_gnt` rises one cycle after an idle point that sees `acc_req` high. It stays high while `acc_req` is high and falls one cycle after `acc_req` is seen low. `busy` is 0 exactly while idle or granted.
- R7: If no refresh cycle has started for REF_PERIOD cycles, the next idle point drops `ready` and reruns the WAKE_CNT wake-up burst. `ready` returns after that burst.
- R8: A self-refresh request seen at an idle point runs ROWS back-to-back CBR cycles, then one more CBR cycle whose RAS-low phase lasts at least T_RAS cycles and at least T_RASS+1 cycles. That phase ends at the first edge where both minimums are met and `sr_req` is low.
- R9: On leaving self refresh, RAS and CAS stay high for T_RPS cycles. After one idle cycle, ROWS CBR cycles follow, and then the block returns to idle.
- R10: `cash_n` equals `casl_n` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Access engine bus request (level) |
| sr_req | input | 1 | Self-refresh request (level, held for the stay) |
| acc_gnt | output | 1 | Bus granted to the access engine |
| busy | output | 1 | Pause, refresh or self refresh in progress |
| ready | output | 1 | Wake-up sequence complete |
| ras_n | output | 1 | Row strobe, active low, registered |
| casl_n | output | 1 | Low-byte column strobe, active low, registered |
| cash_n | output | 1 | High-byte column strobe, active low, registered |
| we_n | output | 1 | Write enable, held inactive |

## Verification
The hardest case to reach is a lapse. The request must keep the grant for longer than a whole refresh period, and the idle point after its release must still have a refresh due. The stimulus holds `acc_req` high for more than REF_PERIOD cycles, then drops it and checks that the wake-up burst reruns. The priority order is hard to hit as well, because it needs a due slot and a pending request at the same idle point. To get there, the stimulus drops `acc_req` for exactly one cycle after a slot falls due during a grant, and later raises `sr_req` and `acc_req` together. A reference model in the bench follows the same inputs edge by edge and predicts every output.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_WAKE,
    ST_IDLE,
    ST_GRANT,
    ST_REF,
    ST_SR_IN,
    ST_SR_HOLD,
    ST_SR_OUT
  } seq_state_t;

  typedef enum logic [1:0] {
    G_IDLE,
    G_CSR,
    G_RAS,
    G_PRE
  } gen_state_t;

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int INTERVAL  = 3906,
  parameter int LAPSE_CYC = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic due,
  output logic lapse
);
  localparam int IW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam int LW = $clog2(LAPSE_CYC + 1);

  logic [IW-1:0] slot_cnt;
  logic [LW-1:0] since;
  logic          tick;

  assign tick  = (slot_cnt == '0);
  assign lapse = (since == LW'(LAPSE_CYC));

  // free-running slot counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_cnt <= IW'(INTERVAL - 1);
    else if (tick) slot_cnt <= IW'(INTERVAL - 1);
    else slot_cnt <= slot_cnt - IW'(1);
  end

  // a new tick wins over an acknowledge in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) due <= 1'b0;
    else if (tick) due <= 1'b1;
    else if (ack) due <= 1'b0;
  end

  // cycles since the last refresh cycle started, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= '0;
    else if (ack) since <= '0;
    else if (!lapse) since <= since + LW'(1);
  end
endmodule

// File: rtl/cbr_cycle_gen.sv
module cbr_cycle_gen
  import dram_seq_pkg::*;
#(
  parameter int T_CSR = 3,
  parameter int T_RAS = 15,
  parameter int T_RP  = 10,
  parameter int T_RPS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hold,
  input  logic long_pre,
  output logic ras_n,
  output logic cas_n,
  output logic idle,
  output logic done
);
  localparam int M1   = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int M2   = (T_RP > T_RPS) ? T_RP : T_RPS;
  localparam int MAXT = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXT + 1);

  gen_state_t    st, st_n;
  logic [CW-1:0] cnt, cnt_n;

  assign idle = (st == G_IDLE);
  assign done = (st == G_PRE) && (cnt == '0);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    case (st)
      G_IDLE: if (start) begin
        st_n  = G_CSR;
        cnt_n = CW'(T_CSR - 1);
      end
      G_CSR: if (cnt == '0) begin
        st_n  = G_RAS;
        cnt_n = CW'(T_RAS - 1);
      end else cnt_n = cnt - CW'(1);
      G_RAS: if (cnt == '0) begin
        if (!hold) begin
          st_n  = G_PRE;
          cnt_n = long_pre ? CW'(T_RPS - 1) : CW'(T_RP - 1);
        end
      end else cnt_n = cnt - CW'(1);
      G_PRE: if (cnt == '0) begin
        if (start) begin
          st_n  = G_CSR;
          cnt_n = CW'(T_CSR - 1);
        end else st_n = G_IDLE;
      end else cnt_n = cnt - CW'(1);
      default: st_n = G_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= G_IDLE;
      cnt   <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      ras_n <= (st_n != G_RAS);
      cas_n <= !((st_n == G_CSR) || (st_n == G_RAS));
    end
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_seq_pkg::*;
#(
  parameter int PAUSE_CYC  = 50000,
  parameter int WAKE_CNT   = 8,
  parameter int ROWS       = 512,
  parameter int REF_PERIOD = 2000000,
  parameter int T_CSR      = 3,
  parameter int T_RAS      = 15,
  parameter int T_RP       = 10,
  parameter int T_RASS     = 25000,
  parameter int T_RPS      = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  input  logic sr_req,
  output logic acc_gnt,
  output logic busy,
  output logic ready,
  output logic ras_n,
  output logic casl_n,
  output logic cash_n,
  output logic we_n
);
  localparam int INTERVAL = REF_PERIOD / ROWS;
  localparam int PW       = $clog2(PAUSE_CYC);
  localparam int BMAX     = (ROWS > WAKE_CNT) ? ROWS : WAKE_CNT;
  localparam int BW       = $clog2(BMAX + 1);
  localparam int SW       = $clog2(T_RASS + 1);

  seq_state_t    st, st_n;
  logic [PW-1:0] pcnt, pcnt_n;
  logic [BW-1:0] bcnt, bcnt_n;
  logic [SW-1:0] sr_cnt;
  logic          in_burst, start, hold, long_pre;
  logic          g_idle, g_done, g_cas_n;
  logic          due, lapse;

  assign in_burst = (st == ST_WAKE) || (st == ST_REF) || (st == ST_SR_IN) ||
                    (st == ST_SR_HOLD) || (st == ST_SR_OUT);
  assign start    = in_burst && (g_idle || g_done) && (bcnt != '0);
  assign long_pre = (st == ST_SR_HOLD);
  assign hold     = (st == ST_SR_HOLD) && !((sr_cnt >= SW'(T_RASS)) && !sr_req);

  refresh_interval_timer #(
    .INTERVAL (INTERVAL),
    .LAPSE_CYC(REF_PERIOD)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .ack  (start),
    .due  (due),
    .lapse(lapse)
  );

  cbr_cycle_gen #(
    .T_CSR(T_CSR),
    .T_RAS(T_RAS),
    .T_RP (T_RP),
    .T_RPS(T_RPS)
  ) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .hold    (hold),
    .long_pre(long_pre),
    .ras_n   (ras_n),
    .cas_n   (g_cas_n),
    .idle    (g_idle),
    .done    (g_done)
  );

  always_comb begin
    st_n   = st;
    pcnt_n = pcnt;
    bcnt_n = bcnt;
    if (start) bcnt_n = bcnt - BW'(1);
    case (st)
      ST_PAUSE: begin
        if (pcnt == '0) begin
          st_n   = ST_WAKE;
          bcnt_n = BW'(WAKE_CNT);
        end else pcnt_n = pcnt - PW'(1);
      end
      ST_IDLE: begin
        if (lapse) begin
          st_n   = ST_WAKE;
          bcnt_n = BW'(WAKE_CNT);
        end else if (due) begin
          st_n   = ST_REF;
          bcnt_n = BW'(1);
        end else if (sr_req) begin
          st_n   = ST_SR_IN;
          bcnt_n = BW'(ROWS);
        end else if (acc_req) st_n = ST_GRANT;
      end
      ST_GRANT: if (!acc_req) st_n = ST_IDLE;
      default: begin
        if (g_done && (bcnt == '0)) begin
          case (st)
            ST_SR_IN: begin
              st_n   = ST_SR_HOLD;
              bcnt_n = BW'(1);
            end
            ST_SR_HOLD: begin
              st_n   = ST_SR_OUT;
              bcnt_n = BW'(ROWS);
            end
            default: st_n = ST_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_PAUSE;
      pcnt <= PW'(PAUSE_CYC - 1);
      bcnt <= '0;
    end else begin
      st   <= st_n;
      pcnt <= pcnt_n;
      bcnt <= bcnt_n;
    end
  end

  // RAS-low time inside the self-refresh cycle, saturating at T_RASS
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_cnt <= '0;
    else if (st != ST_SR_HOLD) sr_cnt <= '0;
    else if (!ras_n && (sr_cnt != SW'(T_RASS))) sr_cnt <= sr_cnt + SW'(1);
  end

  assign casl_n  = g_cas_n;
  assign cash_n  = g_cas_n;
  assign we_n    = 1'b1;
  assign acc_gnt = (st == ST_GRANT);
  assign busy    = !((st == ST_IDLE) || (st == ST_GRANT));
  assign ready   = !((st == ST_PAUSE) || (st == ST_WAKE));
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int PAUSE_CYC = 50000,
  parameter int T_RAS     = 15
) (
  input logic clk,
  input logic rst_n,
  input logic acc_req,
  input logic acc_gnt,
  input logic busy,
  input logic ready,
  input logic ras_n,
  input logic casl_n,
  input logic cash_n
);
  localparam int PCW = $clog2(PAUSE_CYC + 1);
  localparam int LW  = 16;

  logic [PCW-1:0] since_rst;
  logic [LW-1:0]  low_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != PCW'(PAUSE_CYC)) since_rst <= since_rst + PCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_len <= '0;
    else if (ras_n) low_len <= '0;
    else if (low_len != '1) low_len <= low_len + LW'(1);
  end

  assert_pause_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < PCW'(PAUSE_CYC)) |-> (ras_n && casl_n && cash_n));

  assert_cas_before_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!casl_n && !cash_n && $past(!casl_n)));

  // the counter trails RAS by one cycle, hence T_RAS-1
  assert_ras_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> ($past(low_len) >= LW'(T_RAS - 1)));

  assert_grant_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> (!busy && ras_n && casl_n && cash_n && ready));

  assert_grant_follows_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_gnt) |-> $past(acc_req));

  assert_ras_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> busy);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .PAUSE_CYC(PAUSE_CYC),
  .T_RAS    (T_RAS)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .acc_req(acc_req),
  .acc_gnt(acc_gnt),
  .busy   (busy),
  .ready  (ready),
  .ras_n  (ras_n),
  .casl_n (casl_n),
  .cash_n (cash_n)
);

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;
  localparam int P      = 200;
  localparam int WAKE   = 8;
  localparam int ROWS   = 8;
  localparam int PERIOD = 800;
  localparam int INTV   = PERIOD / ROWS;
  localparam int TCSR   = 2;
  localparam int TRAS   = 4;
  localparam int TRP    = 3;
  localparam int TRASS  = 30;
  localparam int TRPS   = 6;

  logic clk = 0, rst_n = 0, acc_req = 0, sr_req = 0;
  logic acc_gnt, busy, ready, ras_n, casl_n, cash_n, we_n;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(P), .WAKE_CNT(WAKE), .ROWS(ROWS), .REF_PERIOD(PERIOD),
    .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP), .T_RASS(TRASS), .T_RPS(TRPS)
  ) u_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .sr_req(sr_req),
    .acc_gnt(acc_gnt), .busy(busy), .ready(ready), .ras_n(ras_n),
    .casl_n(casl_n), .cash_n(cash_n), .we_n(we_n)
  );

  // reference model state
  int    m_c = 0, m_since = 0;
  bit    m_due = 0;
  bit    e_ras = 1, e_cas = 1, e_busy = 1, e_gnt = 0, e_ready = 0;
  string cur_req = "R1";

  int  n_cmp = 0, n_bad = 0;
  bit  cmp_en = 0, finished = 0;

  task automatic upd(input bit ack, input bit ras, input bit cas);
    m_c++;
    if (m_c % INTV == 0) m_due = 1;
    else if (ack) m_due = 0;
    if (ack) m_since = 0;
    else if (m_since < PERIOD) m_since++;
    e_ras = ras;
    e_cas = cas;
  endtask

  task automatic nxt(input bit ack, input bit ras, input bit cas);
    @(posedge clk);
    upd(ack, ras, cas);
  endtask

  task automatic one_cycle(input bit sr_mode);
    int m;
    nxt(1, 1, 0);
    repeat (TCSR - 1) nxt(0, 1, 0);
    nxt(0, 0, 0);
    m = 1;
    forever begin
      @(posedge clk);
      if (m >= TRAS && (!sr_mode || (m >= TRASS + 1 && !sr_req))) begin
        if (sr_mode) cur_req = "R9";
        upd(0, 1, 1);
        break;
      end
      upd(0, 0, 0);
      m++;
    end
    repeat ((sr_mode ? TRPS : TRP) - 1) nxt(0, 1, 1);
  endtask

  task automatic burst(input int n, input bit sr_mode);
    for (int i = 0; i < n; i++) one_cycle(sr_mode);
  endtask

  task automatic to_idle();
    @(posedge clk);
    upd(0, 1, 1);
    e_busy = 0;
    e_ready = 1;
  endtask

  // behavioural reference, one posedge at a time
  initial begin
    @(posedge rst_n);
    repeat (P) nxt(0, 1, 1);          // R1 pause
    cur_req = "R2";
    burst(WAKE, 0);
    to_idle();
    forever begin
      @(posedge clk);
      if (m_since >= PERIOD) begin
        cur_req = "R7";
        upd(0, 1, 1); e_ready = 0; e_busy = 1;
        burst(WAKE, 0);
        to_idle();
      end else if (m_due) begin
        cur_req = (acc_req || sr_req) ? "R5" : "R4";
        upd(0, 1, 1); e_busy = 1;
        burst(1, 0);
        to_idle();
      end else if (sr_req) begin
        cur_req = acc_req ? "R5" : "R8";
        upd(0, 1, 1); e_busy = 1;
        burst(ROWS, 0);
        cur_req = "R8";
        nxt(0, 1, 1);
        one_cycle(1);
        cur_req = "R9";
        nxt(0, 1, 1);
        burst(ROWS, 0);
        to_idle();
      end else if (acc_req) begin
        cur_req = "R6";
        upd(0, 1, 1); e_gnt = 1;
        forever begin
          @(posedge clk);
          upd(0, 1, 1);
          if (!acc_req) begin e_gnt = 0; break; end
        end
      end else upd(0, 1, 1);
    end
  end

  task automatic chk(input string req, input string sig, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at t=%0t actual=%b expected=%b", req, sig, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(cur_req, "ras_n", ras_n, e_ras);
      chk(cur_req, "casl_n", casl_n, e_cas);
      chk("R10", "cash_n", cash_n, e_cas);
      chk("R3", "we_n", we_n, 1'b1);
      chk("R6", "acc_gnt", acc_gnt, e_gnt);
      chk("R6", "busy", busy, e_busy);
      chk(cur_req, "ready", ready, e_ready);
    end
  end

  task automatic hold_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cmp_en = 1;                        // R1 reset values checked too
    hold_cycles(5);
    rst_n = 1;
    hold_cycles(320);                  // R1 pause, R2 wake burst
    hold_cycles(250);                  // R4 periodic slots
    acc_req = 1; hold_cycles(30);      // R6 short grant
    acc_req = 0; hold_cycles(40);
    acc_req = 1; hold_cycles(150);     // a slot falls due under grant
    acc_req = 0; hold_cycles(1);
    acc_req = 1; hold_cycles(40);      // R5 due slot ahead of request
    acc_req = 0; hold_cycles(30);
    acc_req = 1; hold_cycles(1000);    // R7 lapse
    acc_req = 0; hold_cycles(150);
    sr_req = 1; hold_cycles(200);      // R8 long stay, R9 exit
    sr_req = 0; hold_cycles(250);
    sr_req = 1; hold_cycles(20);       // R8 minimum stay
    sr_req = 0; hold_cycles(250);
    sr_req = 1; acc_req = 1; hold_cycles(10);  // R5 self refresh before access
    sr_req = 0; hold_cycles(200);
    acc_req = 0; hold_cycles(200);
    cmp_en = 0;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule